// File: doc/BRIEF.md
# Shared Address/Data Bus Splitter

This block sits beside a processor whose low address byte and data byte take turns on the same eight wires. At the start of every machine cycle the processor raises an address strobe for one T-state. While that strobe is high, the low address byte is on the shared lines. Later in the cycle the same lines carry data. The block captures the low byte while the strobe is high. It joins that byte with the upper address byte, which arrives on its own wires. The result is a 16-bit address that stays steady for the rest of the cycle.

The block also reads the processor's memory-versus-I/O status level. From it the block produces two cycle qualifiers, one for memory and one for I/O. Both qualifiers stay low while the strobe is high, so no decoder acts on a half-formed address. Once the strobe has fallen, the shared lines pass to a data output with a valid flag.

The capture is a clocked register, not a level latch. While the strobe is high, the low address output is taken straight from the bus, so it is transparent in the same cycle.

Top module: `adbus_split`

## Requirements
- R1: While reset is asserted (rst_n low) the held low address byte is cleared to 0x00, so with the strobe low after reset addr[7:0] reads 0x00.
- R2: While ale is 1, addr[7:0] equals ad_bus in the same cycle.
- R3: Once ale has fallen, addr[7:0] equals the ad_bus value present at the last rising clock edge at which ale was 1. When the strobe stays high for several clocks, the last such value wins.
- R4: While ale stays 0, changes on ad_bus leave addr[7:0] unchanged.
- R5: addr[15:8] always equals hi_addr, whatever the strobe or status.
- R6: mem_sel is 1 exactly when ale is 0 and io_m is 0 (status level 0 means memory).
- R7: io_sel is 1 exactly when ale is 0 and io_m is 1 (status level 1 means I/O).
- R8: While ale is 1 both mem_sel and io_sel are 0, and the two are never 1 together.
- R9: When ale is 0, data_out equals ad_bus and data_vld is 1. When ale is 1, data_out is 0x00 and data_vld is 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock for the low address capture register |
| rst_n | input | 1 | Active-low asynchronous reset |
| ale | input | 1 | Address strobe, high during the first T-state of a cycle |
| io_m | input | 1 | Cycle status: 0 memory, 1 I/O |
| ad_bus | input | 8 | Shared low address / data lines |
| hi_addr | input | 8 | Dedicated upper address byte |
| addr | output | 16 | Recovered address {hi_addr, low byte} |
| mem_sel | output | 1 | Memory cycle qualifier |
| io_sel | output | 1 | I/O cycle qualifier |
| data_out | output | 8 | Data byte from the shared lines after the strobe |
| data_vld | output | 1 | Data byte is valid |

## Verification
The main function is tried with a one-clock strobe followed by data phases. This shows whether the captured byte survives data traffic on the same lines. A strobe held high across several clocks with a changing bus checks that the output follows the bus during the strobe and keeps the last value afterwards. Alternating status levels with the strobe both high and low, together with all-zero and all-one bytes and a changing upper byte, separate the memory and I/O qualifiers, the strobe masking and the byte joining.

// File: rtl/adbus_pkg.sv
package adbus_pkg;

  parameter int unsigned DEF_LO_W = 8;
  parameter int unsigned DEF_HI_W = 8;

  typedef struct packed {
    logic mem;
    logic io;
  } cyc_qual_t;

  // Cycle kind from strobe and status; strobe high masks both.
  function automatic cyc_qual_t qualify(input logic strobe, input logic status,
                                        input logic io_level);
    cyc_qual_t q;
    q.mem = ~strobe & (status != io_level);
    q.io  = ~strobe & (status == io_level);
    return q;
  endfunction

endpackage

// File: rtl/lo_byte_hold.sv
module lo_byte_hold #(
  parameter int unsigned W = 8,
  parameter logic [W-1:0] RST_VAL = '0
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         load,
  input  logic [W-1:0] bus,
  output logic [W-1:0] held,
  output logic [W-1:0] view
);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    held <= RST_VAL;
    else if (load) held <= bus;
  end

  // Transparent view during the strobe, held byte afterwards.
  assign view = load ? bus : held;

endmodule

// File: rtl/cycle_qual.sv
module cycle_qual #(
  parameter logic IO_LEVEL = 1'b1
) (
  input  logic strobe,
  input  logic status,
  output logic mem_sel,
  output logic io_sel
);
  import adbus_pkg::*;

  cyc_qual_t q;

  always_comb q = qualify(strobe, status, IO_LEVEL);

  assign mem_sel = q.mem;
  assign io_sel  = q.io;

endmodule

// File: rtl/data_gate.sv
module data_gate #(
  parameter int unsigned W = 8
) (
  input  logic         strobe,
  input  logic [W-1:0] bus,
  output logic [W-1:0] data,
  output logic         valid
);

  assign valid = ~strobe;
  assign data  = strobe ? '0 : bus;

endmodule

// File: rtl/adbus_split.sv
module adbus_split #(
  parameter int unsigned LO_W = adbus_pkg::DEF_LO_W,
  parameter int unsigned HI_W = adbus_pkg::DEF_HI_W,
  parameter logic        IO_LEVEL = 1'b1,
  parameter logic [LO_W-1:0] LO_RST = '0,
  localparam int unsigned ADDR_W = LO_W + HI_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ale,
  input  logic              io_m,
  input  logic [LO_W-1:0]   ad_bus,
  input  logic [HI_W-1:0]   hi_addr,
  output logic [ADDR_W-1:0] addr,
  output logic              mem_sel,
  output logic              io_sel,
  output logic [LO_W-1:0]   data_out,
  output logic              data_vld
);

  logic            capture_evt;
  logic [LO_W-1:0] lo_held;
  logic [LO_W-1:0] lo_view;

  assign capture_evt = ale;

  lo_byte_hold #(.W(LO_W), .RST_VAL(LO_RST)) u_hold (
    .clk  (clk),
    .rst_n(rst_n),
    .load (capture_evt),
    .bus  (ad_bus),
    .held (lo_held),
    .view (lo_view)
  );

  cycle_qual #(.IO_LEVEL(IO_LEVEL)) u_qual (
    .strobe (ale),
    .status (io_m),
    .mem_sel(mem_sel),
    .io_sel (io_sel)
  );

  data_gate #(.W(LO_W)) u_data (
    .strobe(ale),
    .bus   (ad_bus),
    .data  (data_out),
    .valid (data_vld)
  );

  assign addr = {hi_addr, lo_view};

endmodule

// File: rtl/adbus_split_chk.sv
module adbus_split_chk #(
  parameter int unsigned LO_W = 8,
  parameter int unsigned HI_W = 8
) (
  input logic                 clk,
  input logic                 rst_n,
  input logic                 ale,
  input logic                 io_m,
  input logic [LO_W-1:0]      ad_bus,
  input logic [HI_W-1:0]      hi_addr,
  input logic [LO_W+HI_W-1:0] addr,
  input logic                 mem_sel,
  input logic                 io_sel,
  input logic [LO_W-1:0]      data_out,
  input logic                 data_vld
);

  p_transparent_r2: assert property (@(posedge clk) disable iff (!rst_n)
    ale |-> addr[LO_W-1:0] == ad_bus);

  p_capture_r3: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(ale) && !ale) |-> addr[LO_W-1:0] == $past(ad_bus));

  p_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (!ale && !$past(ale)) |-> $stable(addr[LO_W-1:0]));

  p_high_r5: assert property (@(posedge clk) disable iff (!rst_n)
    addr[LO_W+HI_W-1:LO_W] == hi_addr);

  p_mem_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (!ale && !io_m) |-> mem_sel);

  p_io_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (!ale && io_m) |-> io_sel);

  p_masked_r8: assert property (@(posedge clk) disable iff (!rst_n)
    ale |-> !mem_sel && !io_sel);

  p_exclusive_r8: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({mem_sel, io_sel}));

  p_data_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !ale |-> data_vld && data_out == ad_bus);

endmodule

bind adbus_split adbus_split_chk #(.LO_W(LO_W), .HI_W(HI_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .ale(ale), .io_m(io_m), .ad_bus(ad_bus),
  .hi_addr(hi_addr), .addr(addr), .mem_sel(mem_sel), .io_sel(io_sel),
  .data_out(data_out), .data_vld(data_vld)
);

// File: tb/adbus_split_bench.sv
`timescale 1ns/1ps
module adbus_split_bench;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        ale = 1'b0;
  logic        io_m = 1'b0;
  logic [7:0]  ad_bus = 8'h00;
  logic [7:0]  hi_addr = 8'h00;
  logic [15:0] addr;
  logic        mem_sel, io_sel, data_vld;
  logic [7:0]  data_out;

  always #2.5 clk = ~clk;

  adbus_split u_adbus_split (
    .clk(clk), .rst_n(rst_n), .ale(ale), .io_m(io_m), .ad_bus(ad_bus),
    .hi_addr(hi_addr), .addr(addr), .mem_sel(mem_sel), .io_sel(io_sel),
    .data_out(data_out), .data_vld(data_vld)
  );

  typedef struct {
    logic [15:0] addr;
    logic        mem;
    logic        io;
    logic [7:0]  data;
    logic        vld;
    string       tag;
  } exp_t;

  exp_t        sb[$];
  int          n_chk = 0;
  int          n_bad = 0;
  logic [7:0]  model_lo = 8'h00;
  bit          done = 1'b0;

  // Driver: apply inputs at the falling edge, predict outputs.
  task automatic drive(input logic a, input logic s, input logic [7:0] d,
                       input logic [7:0] h, input string tag);
    exp_t e;
    @(negedge clk);
    ale = a; io_m = s; ad_bus = d; hi_addr = h;
    e.addr = {h, (a ? d : model_lo)};
    e.mem  = !a && !s;
    e.io   = !a && s;
    e.data = a ? 8'h00 : d;
    e.vld  = !a;
    e.tag  = tag;
    if (a) model_lo = d;
    sb.push_back(e);
  endtask

  // Monitor: compare 1 ns after the rising edge.
  always @(posedge clk) begin
    #1;
    if (sb.size() != 0) begin
      exp_t e;
      e = sb.pop_front();
      n_chk++;
      if (addr !== e.addr || mem_sel !== e.mem || io_sel !== e.io ||
          data_out !== e.data || data_vld !== e.vld) begin
        n_bad++;
        $display("FAIL %s: addr=%h/%h mem=%b/%b io=%b/%b data=%h/%h vld=%b/%b (actual/expected)",
                 e.tag, addr, e.addr, mem_sel, e.mem, io_sel, e.io,
                 data_out, e.data, data_vld, e.vld);
      end
    end
  end

  initial begin
    #100000;
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog: run did not complete");
      $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
      $finish;
    end
  end

  initial begin
    ad_bus = 8'hA5;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    // R1 reset value, R6 memory qualifier, R9 data pass
    drive(1'b0, 1'b0, 8'h5A, 8'h12, "R1 R6 R9 reset low byte");
    // R2 transparency, R8 masking, R9 data blocked
    drive(1'b1, 1'b1, 8'h34, 8'h80, "R2 R8 R9 strobe high");
    // R3 hold after fall, R7 io qualifier
    drive(1'b0, 1'b1, 8'hC7, 8'h80, "R3 R7 held after strobe");
    // R4 bus change ignored
    drive(1'b0, 1'b1, 8'hFF, 8'h80, "R4 bus change ignored");
    drive(1'b0, 1'b0, 8'h00, 8'h80, "R4 R6 bus zero ignored");
    // R5 upper byte follows
    drive(1'b0, 1'b0, 8'h3C, 8'hFE, "R5 upper byte");
    // R2 long strobe, R3 last value wins
    drive(1'b1, 1'b0, 8'h11, 8'h40, "R2 long strobe first");
    drive(1'b1, 1'b1, 8'h22, 8'h40, "R2 R8 long strobe second");
    drive(1'b0, 1'b0, 8'h99, 8'h40, "R3 last strobe value wins");
    // boundary bytes
    drive(1'b1, 1'b0, 8'hFF, 8'hFF, "R2 R8 all ones");
    drive(1'b0, 1'b1, 8'h00, 8'hFF, "R3 R7 R9 all ones held");
    drive(1'b1, 1'b1, 8'h00, 8'h00, "R2 all zeros");
    drive(1'b0, 1'b0, 8'hFF, 8'h00, "R3 R6 all zeros held");
    // walk of machine cycles: one strobe clock, two data clocks
    for (int i = 0; i < 16; i++) begin
      logic [7:0] lo, hi;
      lo = 8'(i * 37 + 5);
      hi = 8'(i * 11 + 3);
      drive(1'b1, i[0], lo, hi, "R2 R8 cycle strobe");
      drive(1'b0, i[0], ~lo, hi, "R3 R6 R7 R9 cycle data");
      drive(1'b0, i[0], 8'(lo ^ 8'h5A), 8'(hi + 1), "R4 R5 cycle data");
    end
    repeat (3) @(negedge clk);
    done = 1'b1;
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end

endmodule